// File: doc/BRIEF.md
# Merging Write Buffer with Read Forwarding

This block sits between a write-through cache and the next memory level. It holds up to a parameter-set number of pending line-sized writes; each slot keeps a line address, a full line of data words and one valid bit per word. A write that names a line already held in a younger slot is folded into that slot. Any other write claims a fresh slot at the tail. Slots leave toward memory strictly oldest first through a valid/ready handshake.

The same write port carries single-word stores and whole dirty lines evicted on a read miss; an eviction is simply a write with every mask bit set. The cache can push one in while its own read request is already on its way. Before a read miss goes to memory, the requester presents the line address on the lookup port. Every held slot is compared in parallel, in the same cycle. For each word, the newest buffered copy is returned along with a word mask, so the requester can take buffered words and fill the rest from memory. A lookup sees the buffer as it stood at the start of the cycle.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is 0, `wr_ready` is 1, and a lookup returns `rd_hit` 0 and `rd_mask` 0.
- R2: A write to a line held in no younger slot takes a new slot. Slots are offered on `mem_*` oldest first. The offered slot stays unchanged while `mem_ready` is low and leaves the buffer on a cycle with `mem_valid` and `mem_ready` both high. Word w of a line occupies bits [w*WORD_W +: WORD_W] of every data bus and bit w of every mask.
- R3: A write whose line matches a valid slot other than the oldest is merged into that slot and takes no new slot. The slot's mask becomes the OR of the old mask and `wr_mask`, and each written word replaces the word held before.
- R4: The oldest slot, the one offered to memory, is never a merge target. A write to its line takes a new slot.
- R5: With every slot in use, `wr_ready` is 0 for a write that matches no mergeable slot and 1 for a write that does. A write is taken only on a cycle with `wr_valid` and `wr_ready` high.
- R6: A lookup of a line held in no slot returns `rd_hit` 0, `rd_full` 0 and `rd_mask` 0.
- R7: When the valid words of all matching slots together cover the whole line, `rd_full` is 1 and `rd_mask` is all ones. This holds even when the words come from two different slots.
- R8: When the matching slots cover only some words, `rd_hit` is 1, `rd_full` is 0, and `rd_mask` marks exactly the covered words with their data on `rd_data`.
- R9: When several slots hold the same word of the looked-up line, `rd_data` carries the copy from the youngest of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| wr_line | input | LINE_W | Line address of the write |
| wr_mask | input | WORDS | Words carried by the write |
| wr_data | input | WORDS*WORD_W | Write data, one word per mask bit |
| rd_valid | input | 1 | Lookup request present |
| rd_line | input | LINE_W | Line address looked up |
| rd_hit | output | 1 | At least one word found in the buffer |
| rd_full | output | 1 | Every word of the line found in the buffer |
| rd_mask | output | WORDS | Words supplied by the buffer |
| rd_data | output | WORDS*WORD_W | Youngest buffered copy of each supplied word |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_ready | input | 1 | Memory takes the offered slot |
| mem_line | output | LINE_W | Line address of the offered slot |
| mem_mask | output | WORDS | Valid words of the offered slot |
| mem_data | output | WORDS*WORD_W | Data of the offered slot |

## Verification
The bench sends a second store to the line that sits in the oldest slot. A design that merged there would change data already offered to memory, and the drained slot count would come out wrong. Lookups are made where the valid words of one line are split across two slots, and where both slots hold the same word. A design that stopped at the first match would report a partial hit or return stale data. A full buffer is probed with a merging write and with a non-merging write: a wrong design either stalls a write it could absorb or overwrites a pending slot. A second round runs with the head pointer away from slot zero, so that age ordering across the pointer wrap is exercised.

// File: rtl/mwb_pkg.sv
`timescale 1ns/1ps
package mwb_pkg;
  parameter int unsigned MWB_NUM_ENT_DEF = 4;
  parameter int unsigned MWB_WORDS_DEF   = 4;
  parameter int unsigned MWB_WORD_W_DEF  = 32;
  parameter int unsigned MWB_LINE_W_DEF  = 26;

  typedef enum logic [1:0] {
    OCC_HOLD  = 2'b00,
    OCC_POP   = 2'b01,
    OCC_PUSH  = 2'b10,
    OCC_SWAP  = 2'b11
  } occ_op_e;
endpackage

// File: rtl/mwb_ctrl.sv
`timescale 1ns/1ps
module mwb_ctrl
  import mwb_pkg::*;
#(
  parameter int unsigned NUM_ENT = MWB_NUM_ENT_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_i,
  input  logic                       pop_i,
  output logic [$clog2(NUM_ENT)-1:0] head_o,
  output logic [$clog2(NUM_ENT)-1:0] tail_o,
  output logic [NUM_ENT-1:0]         ent_valid_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned PTR_W = $clog2(NUM_ENT);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  occ_op_e          op;

  assign op = occ_op_e'({alloc_i, pop_i});

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    unique case (op)
      OCC_PUSH: begin
        tail_d = tail_q + PTR_W'(1);
        cnt_d  = cnt_q + CNT_W'(1);
      end
      OCC_POP: begin
        head_d = head_q + PTR_W'(1);
        cnt_d  = cnt_q - CNT_W'(1);
      end
      OCC_SWAP: begin
        tail_d = tail_q + PTR_W'(1);
        head_d = head_q + PTR_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (alloc_i || pop_i) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      logic [PTR_W-1:0] age;
      age = PTR_W'(i) - head_q;
      ent_valid_o[i] = ({1'b0, age} < cnt_q);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (cnt_q == CNT_W'(NUM_ENT));
  assign empty_o = (cnt_q == '0);

  // R5: no slot is claimed while every slot is occupied
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !full_o);

  // R2: memory never takes a slot from an empty buffer
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/mwb_lookup.sv
`timescale 1ns/1ps
module mwb_lookup
  import mwb_pkg::*;
#(
  parameter int unsigned NUM_ENT = MWB_NUM_ENT_DEF,
  parameter int unsigned WORDS   = MWB_WORDS_DEF,
  parameter int unsigned WORD_W  = MWB_WORD_W_DEF,
  parameter int unsigned LINE_W  = MWB_LINE_W_DEF
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_ENT-1:0]                ent_valid_i,
  input  logic [NUM_ENT*LINE_W-1:0]         ent_line_i,
  input  logic [NUM_ENT*WORDS-1:0]          ent_mask_i,
  input  logic [NUM_ENT*WORDS*WORD_W-1:0]   ent_data_i,
  input  logic [$clog2(NUM_ENT)-1:0]        head_i,
  input  logic [LINE_W-1:0]                 wr_line_i,
  input  logic [LINE_W-1:0]                 rd_line_i,
  output logic                              wr_hit_o,
  output logic [$clog2(NUM_ENT)-1:0]        wr_idx_o,
  output logic [WORDS-1:0]                  rd_mask_o,
  output logic [WORDS*WORD_W-1:0]           rd_data_o
);
  localparam int unsigned PTR_W = $clog2(NUM_ENT);

  logic [NUM_ENT-1:0] wr_cand;
  logic [NUM_ENT-1:0] rd_match;

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_cmp
      logic line_eq_wr, line_eq_rd;
      assign line_eq_wr  = (ent_line_i[g*LINE_W +: LINE_W] == wr_line_i);
      assign line_eq_rd  = (ent_line_i[g*LINE_W +: LINE_W] == rd_line_i);
      assign wr_cand[g]  = ent_valid_i[g] && line_eq_wr && (PTR_W'(g) != head_i);
      assign rd_match[g] = ent_valid_i[g] && line_eq_rd;
    end
  endgenerate

  always_comb begin
    wr_idx_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (wr_cand[i]) wr_idx_o = PTR_W'(i);
    end
  end
  assign wr_hit_o = |wr_cand;

  // walk slots from oldest to youngest so younger words overwrite older ones
  always_comb begin
    rd_mask_o = '0;
    rd_data_o = '0;
    for (int a = 0; a < NUM_ENT; a++) begin
      logic [PTR_W-1:0] idx;
      idx = head_i + PTR_W'(a);
      if (rd_match[idx]) begin
        for (int w = 0; w < WORDS; w++) begin
          if (ent_mask_i[idx*WORDS + w]) begin
            rd_mask_o[w] = 1'b1;
            rd_data_o[w*WORD_W +: WORD_W] = ent_data_i[(idx*WORDS + w)*WORD_W +: WORD_W];
          end
        end
      end
    end
  end

  // R3: a line lives in at most one mergeable slot
  assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_cand));

  // R4: the slot offered to memory is never picked for merging
  assert_head_not_merged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_o |-> (wr_idx_o != head_i));
endmodule

// File: rtl/merge_wbuf.sv
`timescale 1ns/1ps
module merge_wbuf
  import mwb_pkg::*;
#(
  parameter int unsigned NUM_ENT = MWB_NUM_ENT_DEF,
  parameter int unsigned WORDS   = MWB_WORDS_DEF,
  parameter int unsigned WORD_W  = MWB_WORD_W_DEF,
  parameter int unsigned LINE_W  = MWB_LINE_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [LINE_W-1:0]         wr_line,
  input  logic [WORDS-1:0]          wr_mask,
  input  logic [WORDS*WORD_W-1:0]   wr_data,
  input  logic                      rd_valid,
  input  logic [LINE_W-1:0]         rd_line,
  output logic                      rd_hit,
  output logic                      rd_full,
  output logic [WORDS-1:0]          rd_mask,
  output logic [WORDS*WORD_W-1:0]   rd_data,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic [LINE_W-1:0]         mem_line,
  output logic [WORDS-1:0]          mem_mask,
  output logic [WORDS*WORD_W-1:0]   mem_data
);
  localparam int unsigned PTR_W     = $clog2(NUM_ENT);
  localparam int unsigned LINE_BITS = WORDS * WORD_W;

  logic [PTR_W-1:0]            head, tail, merge_idx;
  logic [NUM_ENT-1:0]          ent_valid;
  logic                        full, empty, merge_hit;
  logic                        accept, do_merge, do_alloc, do_pop;
  logic [NUM_ENT*LINE_W-1:0]   ent_line;
  logic [NUM_ENT*WORDS-1:0]    ent_mask;
  logic [NUM_ENT*LINE_BITS-1:0] ent_data;
  logic [WORDS-1:0]            fwd_mask;
  logic [LINE_BITS-1:0]        fwd_data;

  mwb_ctrl #(.NUM_ENT(NUM_ENT)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_i    (do_alloc),
    .pop_i      (do_pop),
    .head_o     (head),
    .tail_o     (tail),
    .ent_valid_o(ent_valid),
    .full_o     (full),
    .empty_o    (empty)
  );

  mwb_lookup #(
    .NUM_ENT(NUM_ENT), .WORDS(WORDS), .WORD_W(WORD_W), .LINE_W(LINE_W)
  ) lookup_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_valid_i(ent_valid),
    .ent_line_i (ent_line),
    .ent_mask_i (ent_mask),
    .ent_data_i (ent_data),
    .head_i     (head),
    .wr_line_i  (wr_line),
    .rd_line_i  (rd_line),
    .wr_hit_o   (merge_hit),
    .wr_idx_o   (merge_idx),
    .rd_mask_o  (fwd_mask),
    .rd_data_o  (fwd_data)
  );

  assign wr_ready = merge_hit || !full;
  assign accept   = wr_valid && wr_ready;
  assign do_merge = accept && merge_hit;
  assign do_alloc = accept && !merge_hit;
  assign do_pop   = mem_valid && mem_ready;

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_slot
      logic                 alloc_here, merge_here;
      logic [LINE_W-1:0]    line_r;
      logic [WORDS-1:0]     mask_r, mask_d;
      logic [LINE_BITS-1:0] data_r;
      logic [WORDS-1:0]     word_we;

      assign alloc_here = do_alloc && (tail == PTR_W'(g));
      assign merge_here = do_merge && (merge_idx == PTR_W'(g));
      assign word_we    = (alloc_here || merge_here) ? wr_mask : '0;

      always_comb begin
        mask_d = mask_r;
        if (alloc_here)      mask_d = wr_mask;
        else if (merge_here) mask_d = mask_r | wr_mask;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        mask_r <= '0;
        else if (alloc_here || merge_here) mask_r <= mask_d;
      end

      always_ff @(posedge clk) begin
        if (alloc_here) line_r <= wr_line;
      end

      always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
          if (word_we[w]) data_r[w*WORD_W +: WORD_W] <= wr_data[w*WORD_W +: WORD_W];
        end
      end

      assign ent_line[g*LINE_W +: LINE_W]       = line_r;
      assign ent_mask[g*WORDS +: WORDS]         = mask_r;
      assign ent_data[g*LINE_BITS +: LINE_BITS] = data_r;
    end
  endgenerate

  assign mem_valid = !empty;
  assign mem_line  = ent_line[head*LINE_W +: LINE_W];
  assign mem_mask  = ent_mask[head*WORDS +: WORDS];
  assign mem_data  = ent_data[head*LINE_BITS +: LINE_BITS];

  assign rd_mask = rd_valid ? fwd_mask : '0;
  assign rd_data = rd_valid ? fwd_data : '0;
  assign rd_hit  = |rd_mask;
  assign rd_full = &rd_mask;

  // R2: a slot offered to memory does not change until it is taken
  assert_head_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_line) && $stable(mem_mask)
                                   && $stable(mem_data)));

  // R5: back-pressure only ever appears with pending slots
  assert_stall_needs_content_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> mem_valid);

  // R1: an empty buffer supplies nothing to a lookup
  assert_empty_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> !rd_hit);
endmodule

// File: tb/merge_wbuf_tb.sv
`timescale 1ns/1ps
module merge_wbuf_tb_top;
  localparam int N  = 4;
  localparam int WP = 4;
  localparam int WW = 32;
  localparam int LW = 26;
  localparam int LB = WP * WW;

  typedef struct packed {
    logic [LW-1:0] line;
    logic [WP-1:0] mask;
    logic [LB-1:0] data;
  } slot_t;

  slot_t exp_q[$];

  logic          clk, rst_n;
  logic          wr_valid, wr_ready;
  logic [LW-1:0] wr_line;
  logic [WP-1:0] wr_mask;
  logic [LB-1:0] wr_data;
  logic          rd_valid, rd_hit, rd_full;
  logic [LW-1:0] rd_line;
  logic [WP-1:0] rd_mask;
  logic [LB-1:0] rd_data;
  logic          mem_valid, mem_ready;
  logic [LW-1:0] mem_line;
  logic [WP-1:0] mem_mask;
  logic [LB-1:0] mem_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  merge_wbuf #(.NUM_ENT(N), .WORDS(WP), .WORD_W(WW), .LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line),
    .wr_mask(wr_mask), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_line(rd_line), .rd_hit(rd_hit), .rd_full(rd_full),
    .rd_mask(rd_mask), .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_line(mem_line),
    .mem_mask(mem_mask), .mem_data(mem_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [LB-1:0] spread(input logic [WP-1:0] m);
    logic [LB-1:0] r;
    r = '0;
    for (int w = 0; w < WP; w++) if (m[w]) r[w*WW +: WW] = '1;
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [LB-1:0] act, input logic [LB-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops the expected slot for every memory handshake
  always @(negedge clk) begin
    if (rst_n && mem_ready && !done) begin
      if (mem_valid) begin
        if (exp_q.size() == 0) begin
          check("R2", "unexpected drain", 1'b1, 1'b0);
        end else begin
          slot_t e;
          e = exp_q.pop_front();
          check("R2", "mem_line", mem_line, e.line);
          check("R2", "mem_mask", mem_mask, e.mask);
          check("R2", "mem_data", mem_data & spread(e.mask), e.data & spread(e.mask));
        end
      end else if (exp_q.size() != 0) begin
        check("R2", "mem_valid with pending slots", mem_valid, 1'b1);
      end
    end
  end

  // driver: starts and ends one time unit after a rising edge
  task automatic do_write(input logic [LW-1:0] line, input logic [WP-1:0] mask,
                          input logic [LB-1:0] data, input string req);
    int    hit;
    logic  exp_rdy;
    slot_t e;
    hit = -1;
    for (int i = 1; i < exp_q.size(); i++) if (exp_q[i].line == line) hit = i;
    wr_valid = 1'b1; wr_line = line; wr_mask = mask; wr_data = data;
    @(negedge clk);
    exp_rdy = (hit >= 0) || (exp_q.size() < N);
    check(req, "wr_ready", wr_ready, exp_rdy);
    if (exp_rdy) begin
      if (hit >= 0) begin
        e = exp_q[hit];
        for (int w = 0; w < WP; w++) if (mask[w]) begin
          e.mask[w] = 1'b1;
          e.data[w*WW +: WW] = data[w*WW +: WW];
        end
        exp_q[hit] = e;
      end else begin
        e.line = line; e.mask = mask; e.data = data & spread(mask);
        exp_q.push_back(e);
      end
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [LW-1:0] line, input string req);
    logic [WP-1:0] em;
    logic [LB-1:0] ed;
    em = '0; ed = '0;
    for (int i = 0; i < exp_q.size(); i++) if (exp_q[i].line == line) begin
      for (int w = 0; w < WP; w++) if (exp_q[i].mask[w]) begin
        em[w] = 1'b1;
        ed[w*WW +: WW] = exp_q[i].data[w*WW +: WW];
      end
    end
    rd_valid = 1'b1; rd_line = line;
    @(negedge clk);
    check(req, "rd_mask", rd_mask, em);
    check(req, "rd_hit",  rd_hit,  |em);
    check(req, "rd_full", rd_full, &em);
    check(req, "rd_data", rd_data & spread(em), ed);
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic do_drain(input int cycles);
    mem_ready = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      @(posedge clk); #1;
    end
    mem_ready = 1'b0;
  endtask

  function automatic logic [LB-1:0] word_at(input int w, input logic [WW-1:0] v);
    logic [LB-1:0] r;
    r = '0;
    r[w*WW +: WW] = v;
    return r;
  endfunction

  localparam logic [LW-1:0] LA = 26'h0000A10;
  localparam logic [LW-1:0] LB_ = 26'h0000B20;
  localparam logic [LW-1:0] LC = 26'h0000C30;
  localparam logic [LW-1:0] LD = 26'h0000D40;
  localparam logic [LW-1:0] LE = 26'h0000E50;
  localparam logic [LW-1:0] LF = 26'h0000F60;
  localparam logic [LW-1:0] LG = 26'h0001070;

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_line = '0; wr_mask = '0; wr_data = '0;
    rd_valid = 1'b0; rd_line = '0; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: empty after reset
    rd_valid = 1'b1; rd_line = LA;
    @(negedge clk);
    check("R1", "mem_valid", mem_valid, 1'b0);
    check("R1", "wr_ready",  wr_ready,  1'b1);
    check("R1", "rd_hit",    rd_hit,    1'b0);
    check("R1", "rd_mask",   rd_mask,   '0);
    @(posedge clk); #1;
    rd_valid = 1'b0;

    // round one
    do_write(LA, 4'b0001, word_at(0, 32'hA0A0_0000), "R2");
    do_write(LA, 4'b0010, word_at(1, 32'hA1A1_0001), "R4");   // head line: new slot
    do_write(LA, 4'b0100, word_at(2, 32'hA2A2_0002), "R3");   // merges into slot 1
    do_write(LB_, 4'b1111, {32'hB3B3_0003, 32'hB2B2_0002, 32'hB1B1_0001, 32'hB0B0_0000}, "R2");
    do_write(LA, 4'b0010, word_at(1, 32'hA1A1_1111), "R3");   // overwrite word 1
    do_read(LA,  "R8");
    do_read(LB_, "R7");
    do_read(LC,  "R6");
    do_write(LC, 4'b1000, word_at(3, 32'hC3C3_0003), "R2");   // buffer now full
    do_write(LD, 4'b0001, word_at(0, 32'hD0D0_0000), "R5");   // refused
    do_write(LA, 4'b1000, word_at(3, 32'hA3A3_0003), "R5");   // merge while full
    do_read(LA,  "R7");                                       // words from two slots
    do_drain(6);
    @(negedge clk);
    check("R2", "mem_valid after drain", mem_valid, 1'b0);
    check("R2", "model empty", exp_q.size() == 0, 1'b1);
    @(posedge clk); #1;

    // round two: head away from slot zero, pointers wrap
    do_write(LE, 4'b0001, word_at(0, 32'hE0E0_0000), "R2");
    do_write(LF, 4'b0010, word_at(1, 32'hF1F1_0001), "R2");
    do_drain(1);
    do_write(LG, 4'b1111, {32'h6363_0003, 32'h6262_0002, 32'h6161_0001, 32'h6060_0000}, "R2");
    do_write(LF, 4'b1000, word_at(3, 32'hF3F3_0003), "R4");   // F is now head
    do_write(LE, 4'b0100, word_at(2, 32'hE2E2_0002), "R2");
    do_read(LF,  "R8");
    do_write(LF, 4'b0010, word_at(1, 32'hF1F1_2222), "R5");   // merge into younger F, full
    do_read(LF,  "R9");
    do_read(LE,  "R8");
    do_drain(5);
    @(negedge clk);
    check("R2", "mem_valid after second drain", mem_valid, 1'b0);
    check("R2", "model empty after second drain", exp_q.size() == 0, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule